// File: doc/BRIEF.md
# Inter-core doorbell register bank

This block is a small memory-mapped register bank through which any bus master can raise an interrupt toward one of several processor cores. Each target core owns one 32-bit ring register. Writing a one to bit 0 of that word fires a one-clock interrupt pulse toward the core. The upper 28 bits of the same word are sticky source flags. Software uses them to record which requester asked for service, under its own convention.

Each core also owns an acknowledge register at a separate offset. The interrupted core writes ones there to clear the flags it has handled. The bank sits behind a plain synchronous slave port with address, write enable, write data, read enable and registered read data. It drives one pulse output per core. The number of cores and the place of the acknowledge bank in the address space are parameters.

Top module: `core_doorbell_regs`

## Requirements
- R1: For core k (0 <= k < NUM_CORES), the ring register sits at byte offset 4*k and the acknowledge register sits at byte offset ACK_BASE + 4*k (ACK_BASE defaults to 0x10). Any address whose two low bits are non-zero is unmapped.
- R2: A write to core k's ring register with bit 0 set drives core_irq[k] high for exactly one clock, in the cycle after the write. All other pulse outputs stay low.
- R3: A write to a ring register with bit 0 clear produces no pulse. A write to an acknowledge register never produces a pulse.
- R4: Read data is presented in the cycle after bus_rd_en. It holds the core's 28 source flags in bits 31..4, and bits 3..0 read as 0 whatever was written to them. In a cycle after one without bus_rd_en, bus_rdata is 0.
- R5: A ring write sets every source flag whose data bit (31..4) is 1 and leaves flags written with 0 unchanged.
- R6: An acknowledge write clears every source flag whose data bit (31..4) is 1 and leaves the others unchanged. Reading the acknowledge register returns the same flags as the ring register.
- R7: After reset, every source flag is 0, every pulse output is 0 and bus_rdata is 0.
- R8: A read of an unmapped address returns 0. A write to one changes no flag and raises no pulse.
- R9: Ring writes with bit 0 set in consecutive cycles give pulses in consecutive cycles.
- R10: A write to one core's registers changes neither another core's flags nor its pulse output.
- R11: When a read and a write hit the same register in one cycle, the read returns the flags as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| core_irq | output | NUM_CORES | One interrupt pulse per core |

## Verification
The bench builds two copies of the block from the same stimulus: one with two cores and one with a single core, both with ADDR_W = 8 and ACK_BASE = 0x10. The two-core build reaches cross-core isolation and trigger pulses that alternate between cores. In the single-core build, the offsets that belong to the second core (0x04 and 0x14) become unmapped, so the same traffic checks the address-map edge set by the core count. A behavioural model tracks the flags of both builds. It is compared with both on every clock, through directed cases and a stretch of pseudo-random traffic.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

   // Layout of one ring / acknowledge word
   localparam int unsigned REG_W    = 32;
   localparam int unsigned TRIG_BIT = 0;
   localparam int unsigned SRC_LSB  = 4;
   localparam int unsigned SRC_W    = REG_W - SRC_LSB;

   // Which register bank an access lands in
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RING = 2'd1,
      ACC_ACK  = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned ACK_BASE  = 16,
   localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_CORES-1:0] ring_hit,
   output logic [NUM_CORES-1:0] ack_hit,
   output acc_kind_e            kind,
   output logic [IDX_W-1:0]     idx
);

   // One comparator per register; the match vectors drive the write enables
   for (genvar k = 0; k < NUM_CORES; k++) begin : g_match
      assign ring_hit[k] = (addr == ADDR_W'(4 * k));
      assign ack_hit[k]  = (addr == ADDR_W'(ACK_BASE + 4 * k));
   end

   always_comb begin
      if (|ring_hit)     kind = ACC_RING;
      else if (|ack_hit) kind = ACC_ACK;
      else               kind = ACC_NONE;
   end

   // Core index for the read path; a single core needs no encoder
   if (NUM_CORES == 1) begin : g_idx_single
      assign idx = '0;
   end else begin : g_idx_enc
      always_comb begin
         idx = '0;
         for (int k = 0; k < NUM_CORES; k++) begin
            if (ring_hit[k] || ack_hit[k]) idx = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/doorbell_slot.sv
module doorbell_slot
   import doorbell_pkg::*;
#(
   parameter int unsigned FLAG_W = SRC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_we,
   input  logic              ack_we,
   input  logic [FLAG_W-1:0] bits,
   input  logic              trig,
   output logic [FLAG_W-1:0] flags_q,
   output logic              irq_q
);

   logic [FLAG_W-1:0] set_mask;
   logic [FLAG_W-1:0] clr_mask;
   logic [FLAG_W-1:0] flags_d;

   assign set_mask = ring_we ? bits : '0;
   assign clr_mask = ack_we  ? bits : '0;
   // Clear first, then set: a set arriving with a clear is never lost
   assign flags_d  = (flags_q & ~clr_mask) | set_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         irq_q   <= ring_we & trig;
      end
   end

   // R2: trigger write is followed by a pulse
   a_r2_pulse_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_we && trig) |=> irq_q);

   // R3: no pulse without a trigger write
   a_r3_no_pulse_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_we && trig) |=> !irq_q);

   // R5: written ones stick
   a_r5_set_bits_stick: assert property (@(posedge clk) disable iff (!rst_n)
      ring_we |=> ((flags_q & $past(bits)) == $past(bits)));

   // R5: written zeros keep the old flag
   a_r5_zero_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_we && !ack_we) |=> ((flags_q & ~$past(bits)) == ($past(flags_q) & ~$past(bits))));

   // R6: acknowledged flags are cleared
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && !ring_we) |=> ((flags_q & $past(bits)) == '0));

   // R10: flags hold when this slot is not written
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_we || ack_we) |=> $stable(flags_q));

endmodule

// File: rtl/doorbell_rdmux.sv
module doorbell_rdmux
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rd_en,
   input  acc_kind_e                         kind,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [NUM_CORES-1:0][SRC_W-1:0]   flags,
   output logic [REG_W-1:0]                  rdata
);

   logic [SRC_W-1:0] sel;
   assign sel = flags[idx];

   // Registered read; the value is the one before this cycle's write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en && (kind != ACC_NONE)) begin
         rdata <= {sel, {SRC_LSB{1'b0}}};
      end else begin
         rdata <= '0;
      end
   end

endmodule

// File: rtl/core_doorbell_regs.sv
module core_doorbell_regs
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned ACK_BASE  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr_en,
   input  logic [REG_W-1:0]     bus_wdata,
   input  logic                 bus_rd_en,
   output logic [REG_W-1:0]     bus_rdata,
   output logic [NUM_CORES-1:0] core_irq
);

   localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int unsigned RING_END = 4 * NUM_CORES;
   localparam int unsigned ACK_END  = ACK_BASE + 4 * NUM_CORES;

   // Elaboration-time parameter checks
   if (NUM_CORES < 1) begin : g_chk_cores
      $error("core_doorbell_regs: NUM_CORES must be at least 1");
   end
   if ((ACK_BASE % 4) != 0) begin : g_chk_align
      $error("core_doorbell_regs: ACK_BASE must be word aligned");
   end
   if (ACK_BASE < RING_END) begin : g_chk_overlap
      $error("core_doorbell_regs: acknowledge bank overlaps ring bank");
   end
   if (ACK_END > (1 << ADDR_W)) begin : g_chk_space
      $error("core_doorbell_regs: register map exceeds address space");
   end

   logic [NUM_CORES-1:0]            ring_hit;
   logic [NUM_CORES-1:0]            ack_hit;
   acc_kind_e                       kind;
   logic [IDX_W-1:0]                idx;
   logic [NUM_CORES-1:0][SRC_W-1:0] flags_all;

   doorbell_decode #(
      .NUM_CORES (NUM_CORES),
      .ADDR_W    (ADDR_W),
      .ACK_BASE  (ACK_BASE)
   ) u_decode (
      .addr     (bus_addr),
      .ring_hit (ring_hit),
      .ack_hit  (ack_hit),
      .kind     (kind),
      .idx      (idx)
   );

   for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
      doorbell_slot #(
         .FLAG_W (SRC_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .ring_we (bus_wr_en & ring_hit[k]),
         .ack_we  (bus_wr_en & ack_hit[k]),
         .bits    (bus_wdata[REG_W-1:SRC_LSB]),
         .trig    (bus_wdata[TRIG_BIT]),
         .flags_q (flags_all[k]),
         .irq_q   (core_irq[k])
      );
   end

   doorbell_rdmux #(
      .NUM_CORES (NUM_CORES)
   ) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (bus_rd_en),
      .kind  (kind),
      .idx   (idx),
      .flags (flags_all),
      .rdata (bus_rdata)
   );

   // R1: an address selects at most one register
   a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ring_hit, ack_hit}));

   // R2: never more than one core pulsed at once
   a_r2_one_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_irq));

   // R4: trigger and reserved bits never read back
   a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[SRC_LSB-1:0] == '0);

   // R4: reserved write bits have no visible effect
   a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && (|bus_wdata[SRC_LSB-1:TRIG_BIT+1])) |=> (bus_rdata[SRC_LSB-1:TRIG_BIT+1] == '0));

   // R4: no read strobe, zero read data
   a_r4_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> (bus_rdata == '0));

   // R8: unmapped read returns zero
   a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && kind == ACC_NONE) |=> (bus_rdata == '0));

   // R8: unmapped write is inert
   a_r8_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && kind == ACC_NONE) |=> ((core_irq == '0) && $stable(flags_all)));

endmodule

// File: tb/core_doorbell_regs_test.sv
`timescale 1ns/1ps
module core_doorbell_regs_test;

   localparam int ACKB = 'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] rd_a, rd_b;
   logic [1:0]  irq_a;
   logic [0:0]  irq_b;

   always #2 clk = ~clk;

   core_doorbell_regs #(.NUM_CORES(2), .ADDR_W(8), .ACK_BASE(ACKB)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(we),
      .bus_wdata(wd), .bus_rd_en(re), .bus_rdata(rd_a), .core_irq(irq_a));

   core_doorbell_regs #(.NUM_CORES(1), .ADDR_W(8), .ACK_BASE(ACKB)) uut_solo (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(we),
      .bus_wdata(wd), .bus_rd_en(re), .bus_rdata(rd_b), .core_irq(irq_b));

   int    checks = 0;
   int    errors = 0;
   bit    armed = 0;
   bit    done = 0;
   string tag = "R7";
   string tag_q = "R7";

   // Behavioural reference: flags, pulse and read data per build
   int          ncore [2] = '{2, 1};
   logic [27:0] m_src [2][2];
   logic [1:0]  m_irq [2];
   logic [31:0] m_rd  [2];

   function automatic void decode(input logic [7:0] a, input int nc,
                                  output int kind, output int idx);
      int ai;
      ai = int'(a);
      kind = 0;
      idx  = 0;
      if (a[1:0] == 2'b00) begin
         if (ai < 4 * nc) begin
            kind = 1; idx = ai / 4;
         end else if (ai >= ACKB && ai < ACKB + 4 * nc) begin
            kind = 2; idx = (ai - ACKB) / 4;
         end
      end
   endfunction

   always @(posedge clk) begin
      tag_q <= tag;
      for (int i = 0; i < 2; i++) begin
         int kind, idx;
         if (!rst_n) begin
            m_src[i][0] <= '0;
            m_src[i][1] <= '0;
            m_irq[i]    <= '0;
            m_rd[i]     <= '0;
         end else begin
            decode(addr, ncore[i], kind, idx);
            m_rd[i]  <= (re && kind != 0) ? {m_src[i][idx], 4'h0} : 32'h0;
            m_irq[i] <= (we && kind == 1 && wd[0]) ? 2'(1 << idx) : 2'b00;
            if (we && kind == 1)      m_src[i][idx] <= m_src[i][idx] | wd[31:4];
            else if (we && kind == 2) m_src[i][idx] <= m_src[i][idx] & ~wd[31:4];
         end
      end
   end

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag_q, what, act, exp);
      end
   endtask

   // Compare every clock, away from the active edge
   always @(negedge clk) begin
      if (armed && !done) begin
         check("dual rdata", rd_a, m_rd[0]);
         check("dual irq", {30'h0, irq_a}, {30'h0, m_irq[0]});
         check("solo rdata", rd_b, m_rd[1]);
         check("solo irq", {31'h0, irq_b}, {31'h0, m_irq[1][0]});
      end
   end

   task automatic op(input logic [7:0] a, input logic w, input logic [31:0] d,
                     input logic r, input string t);
      @(posedge clk);
      #1;
      addr = a; we = w; wd = d; re = r; tag = t;
   endtask

   task automatic idle(input string t);
      op(8'h00, 1'b0, 32'h0, 1'b0, t);
   endtask

   initial begin
      logic [31:0] lfsr;
      logic [7:0]  alist [8];
      alist = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h08, 8'h18, 8'h03, 8'h11};
      repeat (3) @(posedge clk);
      armed = 1;
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R7: reset state read back
      op(8'h00, 0, 0, 1, "R7");
      op(8'h04, 0, 0, 1, "R7");
      op(8'h10, 0, 0, 1, "R7");
      op(8'h14, 0, 0, 1, "R7");
      // R5, R3: set flags without trigger
      op(8'h00, 1, 32'hA000_0010, 0, "R3");
      op(8'h00, 0, 0, 1, "R5");
      // R4: reserved and trigger bits not stored
      op(8'h04, 1, 32'hFFFF_FFFE, 0, "R4");
      op(8'h04, 0, 0, 1, "R4");
      op(8'h00, 0, 0, 1, "R10");
      // R2: trigger core 0, flags unchanged by zero bits
      op(8'h00, 1, 32'h0000_0001, 0, "R2");
      idle("R2");
      op(8'h00, 0, 0, 1, "R5");
      // R9: back-to-back and alternating triggers
      op(8'h04, 1, 32'h1, 0, "R9");
      op(8'h04, 1, 32'h1, 0, "R9");
      op(8'h00, 1, 32'h1, 0, "R9");
      op(8'h04, 1, 32'h1, 0, "R10");
      idle("R9");
      // R6: acknowledge clears, never pulses, reads same flags
      op(8'h10, 1, 32'h8000_0001, 0, "R6");
      op(8'h10, 0, 0, 1, "R6");
      op(8'h00, 0, 0, 1, "R6");
      op(8'h14, 1, 32'hF000_0000, 1, "R6");
      op(8'h14, 0, 0, 1, "R6");
      // R8 / R1: unmapped and misaligned offsets
      op(8'h08, 1, 32'hFFFF_FFFF, 1, "R8");
      op(8'h02, 1, 32'hFFFF_FFFF, 1, "R1");
      op(8'h18, 1, 32'hFFFF_FFFF, 1, "R8");
      op(8'h13, 1, 32'hFFFF_FFFF, 1, "R1");
      op(8'hFC, 1, 32'hFFFF_FFFF, 1, "R8");
      op(8'h00, 0, 0, 1, "R8");
      op(8'h04, 0, 0, 1, "R1");
      // R11: read and write in one cycle returns old flags
      op(8'h00, 1, 32'h0F00_0001, 1, "R11");
      op(8'h00, 0, 0, 1, "R11");
      op(8'h10, 1, 32'h0F00_0000, 1, "R11");
      op(8'h10, 0, 0, 1, "R11");
      // Pseudo-random traffic
      lfsr = 32'h1BAD_5EED;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         op(alist[lfsr[2:0]], lfsr[3], {lfsr[31:8], lfsr[7:0] ^ lfsr[15:8]}, lfsr[4], "R5");
      end
      // R7: reset in mid-run clears everything
      op(8'h00, 1, 32'hFFFF_FFF1, 0, "R7");
      @(posedge clk);
      #1 rst_n = 1'b0; tag = "R7";
      @(posedge clk);
      #1 rst_n = 1'b1;
      op(8'h00, 0, 0, 1, "R7");
      op(8'h04, 0, 0, 1, "R7");
      idle("R7");
      idle("R7");
      @(negedge clk);
      #1;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired before stimulus ended");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule